// File: doc/BRIEF.md
# Wake Source Aggregation Controller

This block collects wake requests for a low-power controller and records which source caused the wake. It watches five asynchronous pins (three general-purpose pins, a push-button and a serial receive line) plus an internal countdown timer. Every pin is brought into the clock domain by a two-stage synchronizer. The block then detects a rising edge or a high level, depending on the source. The push-button also has to pass a sampled debounce filter before it can count.

Software programs a six-bit enable register and clears flags through a write-one-to-clear register. Both use one small register write port. A sleep input tells the block when the part is in its low-power state. While in that state, any set flag produces a single-cycle wake request pulse. Entering sleep wipes all flags, so the flags read after a wake show only what happened during that sleep. The timer counts slow ticks, and it counts only while sleep is active.

Top module: `wake_agg`

## Requirements
- R1: After reset all enables and flags are 0 and `wake_req` is 0.
- R2: General pin A (flag bit 0) and the receive pin (flag bit 4) set their flag only on a rising edge of the synchronized pin. A pin that stays high does not set the flag again after it has been cleared.
- R3: General pins B (bit 1) and C (bit 2) set their flag whenever the synchronized pin is high. A flag cleared while its pin is still high is set again at once.
- R4: A flag is held at 0 in every cycle in which its enable bit is 0. Clearing an enable clears its flag on the same clock edge.
- R5: A general pin (bits 0 to 2) can set its flag only while the matching `gp_is_input` bit is 1. Otherwise its enable has no effect.
- R6: The push-button (bit 3) sets its flag only after the synchronized pin has been high on 32 consecutive `slow_tick` samples. It does not set the flag after 31.
- R7: If the synchronized push-button goes low at any point, the debounce count restarts from zero.
- R8: Writing the enable register (address 0) with bit 5 set arms the timer and loads it from `tmr_load`. The timer decrements only on ticks while sleep is active. It sets flag bit 5 on the `tmr_load`-th such tick (on the first tick if the load value is 0) and then disarms itself.
- R9: While sleep is active, the moment at least one flag becomes set produces exactly one `wake_req` pulse, one cycle wide. No pulse is produced outside sleep.
- R10: A write to address 1 clears exactly the flags whose data bits are 1 and leaves the other flags unchanged.
- R11: On entry into sleep (the first cycle `sleep_mode` is high), all flags are cleared, and the stale flags do not produce a wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 5 | Asynchronous pins: 0 pin A, 1 pin B, 2 pin C, 3 push-button, 4 serial receive |
| gp_is_input | input | 3 | Per general pin: 1 when configured as a digital input |
| sleep_mode | input | 1 | High while the part is in a low-power mode |
| slow_tick | input | 1 | One-cycle sampling strobe (nominally every 2 ms) |
| tmr_load | input | TMR_W | Timer reload value used when the timer is armed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 enable register, 1 flag clear (write-one-to-clear) |
| reg_wdata | input | 6 | Write data, one bit per source (bit 5 is the timer/arm bit) |
| wake_req | output | 1 | Single-cycle wake request pulse |
| wake_flags | output | 6 | Per-source wake flags |

## Verification
Several internal faults show up at the ports. A stuck or off-by-one debounce counter moves the push-button flag by one tick relative to the 32nd sample. A lost edge register turns a rising-edge source into a level source, and the fault appears the first time a flag is cleared while its pin stays high. A timer that counts outside sleep, or that reloads wrongly, makes flag bit 5 rise on the wrong tick, and the matching wake pulse follows one cycle later. A missing entry clear is seen as a spurious pulse or a non-zero flag two cycles after sleep is asserted.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int NPIN = 5;
    localparam int NGP  = 3;
    localparam int NSRC = 6;

    localparam int SRC_GPA = 0;
    localparam int SRC_GPB = 1;
    localparam int SRC_GPC = 2;
    localparam int SRC_BTN = 3;
    localparam int SRC_RXD = 4;
    localparam int SRC_TMR = 5;

    typedef logic [NSRC-1:0] src_vec_t;

    // 1 = rising-edge source, 0 = high-level source (pin sources only)
    localparam src_vec_t RISE_MODE = 6'b01_0001;

    typedef enum logic {
        REG_ENABLE  = 1'b0,
        REG_FLAGCLR = 1'b1
    } reg_addr_t;

    typedef struct packed {
        logic wr_en;
        logic wr_clr;
    } reg_op_t;

    function automatic reg_op_t decode_op(input logic wr, input reg_addr_t addr);
        reg_op_t op;
        op.wr_en  = wr && (addr == REG_ENABLE);
        op.wr_clr = wr && (addr == REG_FLAGCLR);
        return op;
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
    parameter int SAMPLES = 32,
    parameter int CW      = $clog2(SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          level,
    input  logic          tick,
    output logic          stable,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    always_ff @(posedge clk) begin
        if (rst || !level) begin
            cnt <= '0;
        end else if (tick && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stable = (cnt == FULL);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic          fire
);
    logic          armed;
    logic [TW-1:0] cnt;
    logic          step;

    assign step = armed && run && tick && !load;
    assign fire = step && (cnt <= TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            armed <= 1'b1;
            cnt   <= load_val;
        end else if (step) begin
            if (cnt <= TW'(1)) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wake_agg.sv
module wake_agg
    import wake_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int DB_SAMPLES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pin_raw,
    input  logic [NGP-1:0]   gp_is_input,
    input  logic             sleep_mode,
    input  logic             slow_tick,
    input  logic [TMR_W-1:0] tmr_load,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [NSRC-1:0]  reg_wdata,
    output logic             wake_req,
    output logic [NSRC-1:0]  wake_flags
);
    localparam int DB_CW = $clog2(DB_SAMPLES + 1);

    reg_op_t          op;
    logic [NPIN-1:0]  pin_s;
    src_vec_t         en_q, en_nx, gate, hit, clr_mask, flags_nx;
    logic             sleep_q, entry;
    logic             btn_lvl, btn_ok, tmr_fire;
    logic [DB_CW-1:0] db_cnt;
    logic             req_cond, req_prev;

    assign op = decode_op(reg_wr, reg_addr_t'(reg_addr));

    wake_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign btn_lvl = pin_s[SRC_BTN];

    wake_debounce #(.SAMPLES(DB_SAMPLES), .CW(DB_CW)) u_db (
        .clk    (clk),
        .rst    (rst),
        .level  (btn_lvl),
        .tick   (slow_tick),
        .stable (btn_ok),
        .cnt    (db_cnt)
    );

    wake_timer #(.TW(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (op.wr_en && reg_wdata[SRC_TMR]),
        .load_val (tmr_load),
        .run      (sleep_q),
        .tick     (slow_tick),
        .fire     (tmr_fire)
    );

    assign en_nx = op.wr_en ? reg_wdata : en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == SRC_BTN) begin : g_btn
            assign hit[i] = btn_ok;
        end else if (i == SRC_TMR) begin : g_tmr
            assign hit[i] = tmr_fire;
        end else if (RISE_MODE[i]) begin : g_rise
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= pin_s[i];
            end
            assign hit[i] = pin_s[i] && !prev_q;
        end else begin : g_level
            assign hit[i] = pin_s[i];
        end

        if (i < NGP) begin : g_cfg
            assign gate[i] = en_nx[i] && gp_is_input[i];
        end else begin : g_nocfg
            assign gate[i] = en_nx[i];
        end
    end

    assign entry    = sleep_mode && !sleep_q;
    assign clr_mask = op.wr_clr ? reg_wdata : '0;
    assign flags_nx = (((entry ? '0 : wake_flags) & ~clr_mask) | hit) & gate;

    assign req_cond = sleep_q && (|wake_flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            wake_flags <= '0;
            sleep_q    <= 1'b0;
            req_prev   <= 1'b0;
            wake_req   <= 1'b0;
        end else begin
            en_q       <= en_nx;
            wake_flags <= flags_nx;
            sleep_q    <= sleep_mode;
            req_prev   <= req_cond;
            wake_req   <= req_cond && !req_prev;
        end
    end
endmodule

// File: rtl/wake_agg_chk.sv
module wake_agg_chk
    import wake_pkg::*;
#(
    parameter int DB_SAMPLES = 32,
    parameter int DB_CW      = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wake_req,
    input logic [NSRC-1:0]  wake_flags,
    input logic [NSRC-1:0]  en_q,
    input logic             sleep_mode,
    input logic             btn_lvl,
    input logic [DB_CW-1:0] db_cnt
);
    a_r4_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (wake_flags & ~en_q) == '0);

    a_r6_btn_after_full_count: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flags[SRC_BTN]) |-> ($past(db_cnt) == DB_CW'(DB_SAMPLES)));

    a_r7_low_restarts_count: assert property (@(posedge clk) disable iff (rst)
        !btn_lvl |=> (db_cnt == '0));

    a_r8_timer_only_in_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flags[SRC_TMR]) |-> $past(sleep_mode, 2));

    a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    a_r9_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(|wake_flags));
endmodule

bind wake_agg wake_agg_chk #(.DB_SAMPLES(DB_SAMPLES), .DB_CW(DB_CW)) u_chk (.*);

// File: tb/wake_agg_tb_top.sv
module wake_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  pin_raw = '0;
    logic [2:0]  gp_is_input = '0;
    logic        sleep_mode = 1'b0;
    logic        slow_tick = 1'b0;
    logic [15:0] tmr_load = '0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [5:0]  reg_wdata = '0;
    logic        wake_req;
    logic [5:0]  wake_flags;

    int n_tests = 0;
    int n_fail  = 0;
    int n_req   = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (!rst && wake_req) n_req++;

    wake_agg dut_i (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .gp_is_input(gp_is_input),
        .sleep_mode(sleep_mode), .slow_tick(slow_tick), .tmr_load(tmr_load),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wake_req(wake_req), .wake_flags(wake_flags)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic a, input logic [5:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; pin_raw = '0; gp_is_input = '0; sleep_mode = 1'b0;
        slow_tick = 1'b0; reg_wr = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 flags after reset", wake_flags, 0);
        check("R1 wake_req after reset", wake_req, 0);
    endtask

    task automatic t_edges;
        do_reset();
        gp_is_input = 3'b111;
        wr(1'b0, 6'b01_0001);
        pin_raw[0] = 1'b1; pin_raw[4] = 1'b1;
        cyc(4);
        check("R2 pin A rising sets flag", wake_flags[0], 1);
        check("R2 rx rising sets flag", wake_flags[4], 1);
        wr(1'b1, 6'b00_0001);
        cyc(4);
        check("R10 clear bit0 only, bit0", wake_flags[0], 0);
        check("R10 clear bit0 only, bit4", wake_flags[4], 1);
        check("R2 steady high does not re-set", wake_flags[0], 0);
    endtask

    task automatic t_levels;
        do_reset();
        gp_is_input = 3'b111;
        wr(1'b0, 6'b00_0010);
        pin_raw[1] = 1'b1;
        cyc(4);
        check("R3 pin B high sets flag", wake_flags[1], 1);
        wr(1'b1, 6'b00_0010);
        cyc(2);
        check("R3 clear while high re-sets", wake_flags[1], 1);
        pin_raw[1] = 1'b0;
        cyc(4);
        wr(1'b1, 6'b00_0010);
        cyc(2);
        check("R3 clear after low stays clear", wake_flags[1], 0);
    endtask

    task automatic t_enable;
        do_reset();
        gp_is_input = 3'b111;
        wr(1'b0, 6'b00_0100);
        pin_raw[2] = 1'b1;
        cyc(4);
        check("R4 pin C flag set while enabled", wake_flags[2], 1);
        wr(1'b0, 6'b00_0000);
        check("R4 disable clears flag at once", wake_flags[2], 0);
        cyc(6);
        check("R4 flag held clear while disabled", wake_flags[2], 0);
    endtask

    task automatic t_config;
        do_reset();
        gp_is_input = 3'b000;
        wr(1'b0, 6'b00_0101);
        pin_raw[0] = 1'b1; pin_raw[2] = 1'b1;
        cyc(6);
        check("R5 non-input pins ignored", wake_flags, 0);
    endtask

    task automatic t_button;
        do_reset();
        wr(1'b0, 6'b00_1000);
        pin_raw[3] = 1'b1;
        cyc(3);
        ticks(31);
        cyc(2);
        check("R6 no flag after 31 samples", wake_flags[3], 0);
        ticks(1);
        cyc(1);
        check("R6 flag after 32 samples", wake_flags[3], 1);
        do_reset();
        wr(1'b0, 6'b00_1000);
        pin_raw[3] = 1'b1;
        cyc(3);
        ticks(20);
        pin_raw[3] = 1'b0;
        cyc(3);
        pin_raw[3] = 1'b1;
        cyc(3);
        ticks(31);
        cyc(2);
        check("R7 glitch restarts count, 31 after", wake_flags[3], 0);
        ticks(1);
        cyc(1);
        check("R7 flag after full 32 post-glitch", wake_flags[3], 1);
    endtask

    task automatic t_sleep;
        int base;
        do_reset();
        gp_is_input = 3'b111;
        wr(1'b0, 6'b00_0010);
        pin_raw[1] = 1'b1;
        cyc(4);
        pin_raw[1] = 1'b0;
        cyc(4);
        check("R11 flag set before sleep", wake_flags[1], 1);
        base = n_req;
        sleep_mode = 1'b1;
        cyc(4);
        check("R11 entry clears flags", wake_flags, 0);
        check("R11 no request from stale flag", n_req - base, 0);
        pin_raw[1] = 1'b1;
        cyc(8);
        check("R9 one pulse on wake in sleep", n_req - base, 1);
        sleep_mode = 1'b0;
        cyc(2);
        do_reset();
        gp_is_input = 3'b111;
        wr(1'b0, 6'b00_0010);
        base = n_req;
        pin_raw[1] = 1'b1;
        cyc(8);
        check("R9 no pulse outside sleep", n_req - base, 0);
    endtask

    task automatic t_timer;
        int base;
        do_reset();
        tmr_load = 16'd5;
        wr(1'b0, 6'b10_0000);
        ticks(10);
        check("R8 no countdown outside sleep", wake_flags[5], 0);
        base = n_req;
        sleep_mode = 1'b1;
        cyc(2);
        ticks(4);
        check("R8 no fire after 4 of 5 ticks", wake_flags[5], 0);
        ticks(1);
        check("R8 fires on 5th tick", wake_flags[5], 1);
        cyc(3);
        check("R9 timer wake pulse", n_req - base, 1);
        wr(1'b1, 6'b10_0000);
        ticks(10);
        check("R8 one-shot after fire", wake_flags[5], 0);
        do_reset();
        tmr_load = 16'd0;
        wr(1'b0, 6'b10_0000);
        sleep_mode = 1'b1;
        cyc(2);
        ticks(1);
        check("R8 zero load fires on first tick", wake_flags[5], 1);
    endtask

    initial begin
        t_reset();
        t_edges();
        t_levels();
        t_enable();
        t_config();
        t_button();
        t_sleep();
        t_timer();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (R1..) actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule